// File: doc/BRIEF.md
# Receive-Port Alarm Status Latch with Masked Interrupt

This block keeps the alarm state of one receive port. Three loss-of-lock levels (descrambler, container delineation, frame delineation), a received 8-bit link label, an expected link label and a message-buffer-full pulse feed it. Each alarm condition sets a sticky bit in a status byte. A change in any of the three lock levels, in either direction, sets a derived change-of-status bit. Label changes and label mismatches are caught by comparing the received label with its own value one cycle earlier, and with the expected label.

A processor reaches two byte-wide registers through a simple read and write strobe interface with a one-bit address. Reading the status byte returns its contents and clears the alarm bits. An event that arrives in the same cycle as that read survives the clear. The buffer-full bit is cleared only by an explicit write. A second register holds one enable bit per status bit. The single interrupt output is asserted while any enabled status bit is set.

Top module: `rx_alarm_latch`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), the status byte, the enable byte and rdata are all 0x00 and irq is 0.
- R2: Status bit 3 (descrambler), bit 2 (container delineation) and bit 1 (frame delineation) are set in every cycle in which the matching loss-of-lock input is 1, where 1 means out of lock and 0 means in lock. Once set, a bit stays set after the input returns to 0, until a status read clears it.
- R3: Status bit 4 is set in any cycle in which the 3-bit vector {los_descr_i, los_cont_i, los_frame_i} differs from its value in the previous cycle. Both rising and falling changes count, and the previous value after reset is 000.
- R4: Status bit 6 is set in any cycle in which rx_label_i differs from its value in the previous cycle. The previous value after reset is 0x00.
- R5: Status bit 5 is set in any cycle in which rx_label_i differs from exp_label_i.
- R6: A read with rd_en_i=1 and addr_i=0 presents the status byte on rdata one cycle later, with bit 7 always 0. In the same edge it clears status bits 6 down to 1.
- R7: An event that would set a status bit in the same cycle as a clearing read leaves that bit set after the read.
- R8: Status bit 0 is set by a one-cycle pulse on buf_full_i and is not cleared by a status read. A write with wr_en_i=1, addr_i=0 and wdata_i[0]=0 clears it. A write to address 0 with wdata_i[0]=1 leaves it unchanged, and writes to address 0 never alter bits 6 down to 1.
- R9: A write with wr_en_i=1 and addr_i=1 stores wdata_i into the enable byte. A read with addr_i=1 returns that byte on rdata one cycle later. Enable bit 7 is storage only.
- R10: irq equals the OR over bits 6 down to 0 of (status AND enable). It changes in the cycle after the edge that changed either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| los_descr_i | input | 1 | Descrambler loss of lock, 1 = out of lock |
| los_cont_i | input | 1 | Container delineation loss of lock, 1 = out of lock |
| los_frame_i | input | 1 | Frame delineation loss of lock, 1 = out of lock |
| rx_label_i | input | 8 | Received link label |
| exp_label_i | input | 8 | Expected link label |
| buf_full_i | input | 1 | Pulse: a full message is now held |
| rd_en_i | input | 1 | Register read strobe |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 status, 1 enable |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Interrupt, high while an enabled status bit is set |

## Verification
Every result of this block lands one edge after its cause. An alarm input presented before edge E sets its status bit and can raise irq right after E. A read strobe before E puts the pre-clear status on rdata after E, and the cleared bits are seen from then on. The bench drives inputs just after a falling edge and evaluates its requirement-derived expectation for the next rising edge. It compares rdata and irq at the following falling edge, so each comparison sits exactly one register stage after the stimulus. The sweeps cover all 64 ordered pairs of lock-input vectors, all 256 received labels against a fixed expected label, and all 128 masks of the seven live enable bits.

// File: rtl/rx_alarm_pkg.sv
// Package: bit positions and register addresses shared by the alarm latch.
// Assumes an 8-bit status byte whose bit 7 is reserved.
package rx_alarm_pkg;
    localparam int STAT_W      = 8;
    localparam int LIVE_W      = STAT_W - 1;
    localparam int BIT_BUF     = 0;
    localparam int BIT_LOS_FR  = 1;
    localparam int BIT_LOS_CT  = 2;
    localparam int BIT_LOS_DS  = 3;
    localparam int BIT_COS     = 4;
    localparam int BIT_LBL_MIS = 5;
    localparam int BIT_LBL_CHG = 6;
    localparam int NUM_LOS     = 3;
    localparam logic ADDR_STATUS = 1'b0;
    localparam logic ADDR_ENABLE = 1'b1;
    // bits cleared by a status read: 6 down to 1
    localparam logic [LIVE_W-1:0] READ_CLR_MASK = {{(LIVE_W-1){1'b1}}, 1'b0};
endpackage

// File: rtl/rx_alarm_events.sv
// Module: turns raw lock levels and labels into one-cycle set requests.
// Holds the previous lock vector and previous label so that changes can be
// seen. Assumes all inputs are synchronous to clk.
module rx_alarm_events
    import rx_alarm_pkg::*;
#(
    parameter int LABEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_LOS-1:0] los_i,      // {descr, cont, frame}
    input  logic [LABEL_W-1:0] rx_label_i,
    input  logic [LABEL_W-1:0] exp_label_i,
    input  logic               buf_full_i,
    output logic [LIVE_W-1:0]  set_o
);
    logic [NUM_LOS-1:0] prev_los_q;
    logic [LABEL_W-1:0] prev_label_q;

    // Purpose: remember last cycle's lock vector and label.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_los_q   <= '0;
            prev_label_q <= '0;
        end else begin
            prev_los_q   <= los_i;
            prev_label_q <= rx_label_i;
        end
    end

    // Purpose: form the set request for every live status bit.
    always_comb begin
        set_o              = '0;
        set_o[BIT_BUF]     = buf_full_i;
        set_o[BIT_LOS_FR]  = los_i[0];
        set_o[BIT_LOS_CT]  = los_i[1];
        set_o[BIT_LOS_DS]  = los_i[2];
        set_o[BIT_COS]     = (los_i != prev_los_q);
        set_o[BIT_LBL_MIS] = (rx_label_i != exp_label_i);
        set_o[BIT_LBL_CHG] = (rx_label_i != prev_label_q);
    end

    // R3: a change-of-status request implies the lock vector really moved
    assert_cos_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        set_o[BIT_COS] |=> (prev_los_q != $past(prev_los_q)));
endmodule

// File: rtl/rx_alarm_sticky.sv
// Module: bank of sticky flags. A set request always wins over a clear in
// the same cycle, so no event is dropped. Assumes set and clear are
// single-cycle qualified strobes.
module rx_alarm_sticky #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar i = 0; i < W; i++) begin : g_flag
        logic flag_q;

        // Purpose: hold one flag; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        flag_q <= 1'b0;
            else if (set_i[i]) flag_q <= 1'b1;
            else if (clr_i[i]) flag_q <= 1'b0;
        end

        assign q_o[i] = flag_q;

        // R7: a set request is never lost, even against a clear
        assert_event_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[i] |=> q_o[i]);
        // R2: without a clear a set flag stays set
        assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (q_o[i] && !clr_i[i]) |=> q_o[i]);
    end
endmodule

// File: rtl/rx_alarm_latch.sv
// Module: top of the receive-port alarm latch. Combines event detection,
// sticky status, the processor read/write access, the enable byte and the
// masked interrupt. Assumes the processor does not read and write in the
// same cycle; if it does, both take effect.
module rx_alarm_latch
    import rx_alarm_pkg::*;
#(
    parameter int LABEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               los_descr_i,
    input  logic               los_cont_i,
    input  logic               los_frame_i,
    input  logic [LABEL_W-1:0] rx_label_i,
    input  logic [LABEL_W-1:0] exp_label_i,
    input  logic               buf_full_i,
    input  logic               rd_en_i,
    input  logic               wr_en_i,
    input  logic               addr_i,
    input  logic [STAT_W-1:0]  wdata_i,
    output logic [STAT_W-1:0]  rdata_o,
    output logic               irq_o
);
    logic [LIVE_W-1:0] set_w;
    logic [LIVE_W-1:0] clr_w;
    logic [LIVE_W-1:0] status_w;
    logic [STAT_W-1:0] en_q;
    logic [STAT_W-1:0] rdata_q;
    logic              rd_status_w;
    logic              wr_status_w;
    logic              wr_enable_w;

    assign rd_status_w = rd_en_i && (addr_i == ADDR_STATUS);
    assign wr_status_w = wr_en_i && (addr_i == ADDR_STATUS);
    assign wr_enable_w = wr_en_i && (addr_i == ADDR_ENABLE);

    rx_alarm_events #(.LABEL_W(LABEL_W)) u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .los_i      ({los_descr_i, los_cont_i, los_frame_i}),
        .rx_label_i (rx_label_i),
        .exp_label_i(exp_label_i),
        .buf_full_i (buf_full_i),
        .set_o      (set_w)
    );

    // Purpose: read clears bits 6..1; writing 0 to bit 0 clears the buffer flag.
    always_comb begin
        clr_w          = rd_status_w ? READ_CLR_MASK : '0;
        clr_w[BIT_BUF] = wr_status_w && !wdata_i[BIT_BUF];
    end

    rx_alarm_sticky #(.W(LIVE_W)) u_sticky (
        .clk  (clk),
        .rst_n(rst_n),
        .set_i(set_w),
        .clr_i(clr_w),
        .q_o  (status_w)
    );

    // Purpose: processor-written interrupt enable byte.
    always_ff @(posedge clk) begin
        if (!rst_n)           en_q <= '0;
        else if (wr_enable_w) en_q <= wdata_i;
    end

    // Purpose: capture the selected register for the processor.
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= '0;
        else if (rd_en_i)  rdata_q <= (addr_i == ADDR_STATUS) ? {1'b0, status_w} : en_q;
    end

    assign rdata_o = rdata_q;
    assign irq_o   = |(status_w & en_q[LIVE_W-1:0]);

    // R6: a status read with no new alarm event empties bits 6..1
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status_w && (set_w[LIVE_W-1:1] == '0)) |=> (status_w[LIVE_W-1:1] == '0));
    // R5: a label mismatch is visible in the status after the edge
    assert_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_label_i != exp_label_i) |=> status_w[BIT_LBL_MIS]);
    // R9: an enable write lands in the enable byte
    assert_en_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable_w |=> (en_q == $past(wdata_i)));
    // R10: irq only rises after an alarm event or an enable write
    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((|set_w) || wr_enable_w));
    // R6: the reserved status bit never reads as 1
    assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_status_w) |-> !rdata_o[STAT_W-1]);
endmodule

// File: tb/sim_rx_alarm_latch.sv
// Bench: sweeps lock-vector pairs, labels and enable masks, predicting each
// register from the requirements one edge ahead.
module sim_rx_alarm_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       los_d = 0, los_c = 0, los_f = 0;
    logic [7:0] rx_lab = 0, exp_lab = 0;
    logic       buf_set = 0, rd = 0, wr = 0, addr = 0;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // expected state
    logic [6:0] m_st;
    logic [7:0] m_en, m_rd;
    logic [2:0] m_plos;
    logic [7:0] m_plab;

    always #5 clk = ~clk;

    rx_alarm_latch u0 (
        .clk(clk), .rst_n(rst_n),
        .los_descr_i(los_d), .los_cont_i(los_c), .los_frame_i(los_f),
        .rx_label_i(rx_lab), .exp_label_i(exp_lab), .buf_full_i(buf_set),
        .rd_en_i(rd), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one clock: predict from driven inputs, then compare at the next falling edge
    task automatic tick(input string tag);
        logic [6:0] ev, clr, nst;
        ev[0] = buf_set;
        ev[1] = los_f;
        ev[2] = los_c;
        ev[3] = los_d;
        ev[4] = ({los_d, los_c, los_f} != m_plos);
        ev[5] = (rx_lab != exp_lab);
        ev[6] = (rx_lab != m_plab);
        clr    = (rd && !addr) ? 7'b1111110 : 7'b0;
        clr[0] = wr && !addr && !wdata[0];
        nst    = ev | (m_st & ~clr);
        if (rd) m_rd = addr ? m_en : {1'b0, m_st};
        if (wr && addr) m_en = wdata;
        m_st   = nst;
        m_plos = {los_d, los_c, los_f};
        m_plab = rx_lab;
        @(posedge clk);
        @(negedge clk);
        check8({tag, " rdata"}, rdata, m_rd);
        check8({tag, " irq"}, {7'b0, irq}, {7'b0, |(m_st & m_en[6:0])});
    endtask

    task automatic idle();
        rd = 0; wr = 0; buf_set = 0;
    endtask

    task automatic rd_reg(input logic a, input string tag);
        rd = 1; addr = a; tick(tag); idle();
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d, input string tag);
        wr = 1; addr = a; wdata = d; tick(tag); idle();
    endtask

    initial begin
        #1_900_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        m_st = 0; m_en = 0; m_rd = 0; m_plos = 0; m_plab = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1: reset values seen at the ports
        check8("R1 rdata", rdata, 8'h00);
        check8("R1 irq", {7'b0, irq}, 8'h00);
        rd_reg(0, "R1 status");
        rd_reg(1, "R1 enable");

        // R3 / R2 / R7: every ordered pair of lock vectors, then a clearing read
        wr_reg(1, 8'h1E, "R9 enable los");
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                {los_d, los_c, los_f} = a[2:0];
                tick("R2 first");
                {los_d, los_c, los_f} = b[2:0];
                tick("R3 second");
                rd_reg(0, "R7 read during lock level");
                rd_reg(0, "R6 readback");
            end
        end
        {los_d, los_c, los_f} = 3'b000;
        tick("R2 settle");
        rd_reg(0, "R2 clear");
        rd_reg(0, "R6 empty");

        // R4 / R5: all received labels against a fixed expected label
        exp_lab = 8'h5A;
        wr_reg(1, 8'h60, "R9 enable labels");
        for (int v = 0; v < 256; v++) begin
            rx_lab = v[7:0];
            tick("R4 label step");
            rd_reg(0, "R5 label read");
        end
        rx_lab = 8'h5A;
        tick("R4 hold");
        rd_reg(0, "R5 match clear");
        rd_reg(0, "R6 labels empty");

        // R8: buffer-full flag behaviour
        buf_set = 1; tick("R8 set"); idle();
        rd_reg(0, "R8 survives read");
        rd_reg(0, "R8 still set");
        wr_reg(0, 8'hFF, "R8 write one no effect");
        rd_reg(0, "R8 after write one");
        los_f = 1; tick("R8 frame alarm"); los_f = 0; tick("R8 frame cos");
        wr_reg(0, 8'h00, "R8 write zero clears");
        rd_reg(0, "R8 bits 6..1 untouched");
        rd_reg(0, "R8 final");

        // R10 / R9: every mask over all live bits set
        for (int m = 0; m < 256; m++) begin
            wr_reg(1, m[7:0], "R9 mask write");
            rd_reg(1, "R9 mask read");
            los_d = 1; los_c = 1; los_f = 1; rx_lab = 8'h11; buf_set = 1;
            tick("R10 all alarms");
            idle(); los_d = 0; los_c = 0; los_f = 0; rx_lab = 8'h5A;
            tick("R10 alarms held");
            rd_reg(0, "R10 read clears");
            tick("R10 after clear");
            wr_reg(0, 8'h00, "R10 buf clear");
            tick("R10 idle");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule